// File: doc/BRIEF.md
# Page Write Collector

This block sits between a serial-memory bus front end and a nonvolatile array. It collects the data bytes of one write transaction into a sixteen-slot staging area. It then replays them into the array as a short burst when the transaction ends. A word-address load fixes the page, which is the address bits above the low four, and the starting slot, which is the low four bits. Each data byte received lands in the current slot. Only the four-bit slot index then advances, wrapping from 15 to 0, so a long transaction folds back onto its own page. When more than sixteen bytes arrive, the later bytes replace the earlier ones.

A per-slot valid bit records which slots the transaction touched. On commit, only those slots are presented on the write port, each with its full address. The other bytes of the page keep their old contents in the array. The same counter that places the bytes also serves as the read address pointer, so after a write it points one past the last slot written, still inside the page.

Control is a three-state machine:
- ST_IDLE has no transaction open. An address load moves it to ST_FILL. Clear and commit leave it in ST_IDLE.
- ST_FILL is collecting bytes. Clear returns it to ST_IDLE. Commit goes to ST_DRAIN when any slot is valid and to ST_IDLE when none is. An address load restarts the transaction and stays in ST_FILL.
- ST_DRAIN presents one valid slot per clock. It returns to ST_IDLE on the clock that presents the last one.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, wr_en, busy and byte_ack are 0 and next_addr is 0.
- R2: An accepted address load sets next_addr to addr_in. It discards bytes held from any earlier transaction, and the next byte goes to slot addr_in[3:0].
- R3: Each accepted byte advances only next_addr[3:0] by one, wrapping 4'b1111 to 4'b0000. The bits above the low four stay unchanged.
- R4: When more than sixteen bytes arrive in one transaction, byte 16+k overwrites the slot of byte k. Only the newest value of each slot is committed.
- R5: A byte is accepted only in ST_FILL. byte_ack is 1 in the cycle after each accepted byte and 0 otherwise. A byte arriving with no transaction open has no effect on the writes or on next_addr.
- R6: Commit in ST_FILL presents every valid slot exactly once, one per clock, in ascending slot order. Each is presented with wr_addr = {page, slot} and its stored data. Slots not written in the transaction are never presented.
- R7: A transaction of one byte produces exactly one write.
- R8: A commit with no valid slot produces no write and no busy cycle.
- R9: busy is 1 exactly while slots are being presented. While busy, address load, byte, clear and commit inputs have no effect.
- R10: Clear discards the held bytes and closes the transaction without changing next_addr. A later commit writes nothing.
- R11: After the last slot is presented, no slot is valid. A further commit writes nothing until a new address load.
- R12: Inputs given in the same cycle are resolved in this priority: clear, then commit, then address load, then byte. The losing inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Load word address, opening a transaction |
| addr_in | input | ADDR_W | Word address to load |
| byte_valid | input | 1 | Data byte strobe |
| byte_data | input | DATA_W | Data byte |
| commit | input | 1 | End of transaction; start replay into the array |
| clear | input | 1 | Abandon the transaction |
| byte_ack | output | 1 | Byte accepted, one cycle after the strobe |
| busy | output | 1 | Replay in progress |
| wr_en | output | 1 | Array write strobe |
| wr_addr | output | ADDR_W | Array write address |
| wr_data | output | DATA_W | Array write data |
| next_addr | output | ADDR_W | Current address pointer |

## Verification
Several properties are checked by assertions on every cycle:
- consecutive replay writes rise strictly in slot order and stay on one page;
- byte_ack only ever follows a byte strobe;
- the page bits hold across byte acceptance;
- the valid mask is empty when busy falls;
- the slot picked during replay is valid;
- a replay starts only from a commit in ST_FILL.

The scoreboard scenarios are needed to show the rest: which data reaches which address, the write count for the single-byte, empty, cleared and overflowing transactions, the pointer wrap, that inputs are ignored while busy, and the priority between inputs given in the same cycle.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_DRAIN = 2'd2
    } pwb_state_e;
endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
    import pwb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic addr_load,
    input  logic byte_valid,
    input  logic commit,
    input  logic clear,
    input  logic any_valid,
    input  logic one_left,
    output logic take_addr,
    output logic take_byte,
    output logic drop_all,
    output logic drain_step,
    output logic busy,
    output logic byte_ack
);
    pwb_state_e state_q, state_d;
    logic       ack_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: clear > commit > address load > byte
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!clear && !commit && addr_load) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (clear)       state_d = ST_IDLE;
                else if (commit) state_d = any_valid ? ST_DRAIN : ST_IDLE;
            end
            ST_DRAIN: begin
                if (one_left) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        take_addr  = 1'b0;
        take_byte  = 1'b0;
        drop_all   = 1'b0;
        drain_step = 1'b0;
        busy       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                drop_all  = clear | (addr_load & ~commit);
                take_addr = addr_load & ~clear & ~commit;
            end
            ST_FILL: begin
                drop_all  = clear | (addr_load & ~commit);
                take_addr = addr_load & ~clear & ~commit;
                take_byte = byte_valid & ~clear & ~commit & ~addr_load;
            end
            ST_DRAIN: begin
                drain_step = 1'b1;
                busy       = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= take_byte;
    end
    assign byte_ack = ack_q;

    AST_DRAIN_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(state_q) == ST_FILL) && $past(commit) && !$past(clear)); // R6
endmodule

// File: rtl/pwb_addr.sv
module pwb_addr #(
    parameter int ADDR_W = 11,
    parameter int OFS_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_addr,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              take_byte,
    output logic [ADDR_W-OFS_W-1:0] page,
    output logic [OFS_W-1:0]  ofs
);
    logic [ADDR_W-OFS_W-1:0] page_q;
    logic [OFS_W-1:0]        ofs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            ofs_q  <= '0;
        end else if (take_addr) begin
            page_q <= addr_in[ADDR_W-1:OFS_W];
            ofs_q  <= addr_in[OFS_W-1:0];
        end else if (take_byte) begin
            ofs_q  <= ofs_q + 1'b1;
        end
    end

    assign page = page_q;
    assign ofs  = ofs_q;

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take_byte) && !$past(take_addr) |-> page_q == $past(page_q)); // R3
endmodule

// File: rtl/pwb_slots.sv
module pwb_slots #(
    parameter int DATA_W = 8,
    parameter int SLOTS  = 16,
    parameter int OFS_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_byte,
    input  logic [OFS_W-1:0]  wr_slot,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              drop_all,
    input  logic              drain_step,
    output logic [OFS_W-1:0]  pick_slot,
    output logic [DATA_W-1:0] pick_data,
    output logic              any_valid,
    output logic              one_left,
    output logic [SLOTS-1:0]  valid_mask
);
    logic [SLOTS-1:0]  valid_q;
    logic [DATA_W-1:0] data_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic              v_q;
        logic [DATA_W-1:0] d_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= '0;
            end else if (drop_all) begin
                v_q <= 1'b0;
            end else if (take_byte && wr_slot == OFS_W'(g)) begin
                v_q <= 1'b1;
                d_q <= byte_data;
            end else if (drain_step && pick_slot == OFS_W'(g)) begin
                v_q <= 1'b0;
            end
        end
        assign valid_q[g] = v_q;
        assign data_q[g]  = d_q;
    end

    // lowest valid slot wins
    always_comb begin
        pick_slot = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (valid_q[i]) pick_slot = OFS_W'(i);
        end
    end

    assign pick_data  = data_q[pick_slot];
    assign any_valid  = |valid_q;
    assign one_left   = $onehot(valid_q);
    assign valid_mask = valid_q;

    AST_PICK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        drain_step |-> valid_q[pick_slot]); // R6
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              commit,
    input  logic              clear,
    output logic              byte_ack,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] next_addr
);
    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFS_W;

    logic              take_addr, take_byte, drop_all, drain_step;
    logic              any_valid, one_left;
    logic [PAGE_W-1:0] page;
    logic [OFS_W-1:0]  ofs, pick_slot;
    logic [DATA_W-1:0] pick_data;
    logic [PAGE_BYTES-1:0] valid_mask;

    pwb_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_load  (addr_load),
        .byte_valid (byte_valid),
        .commit     (commit),
        .clear      (clear),
        .any_valid  (any_valid),
        .one_left   (one_left),
        .take_addr  (take_addr),
        .take_byte  (take_byte),
        .drop_all   (drop_all),
        .drain_step (drain_step),
        .busy       (busy),
        .byte_ack   (byte_ack)
    );

    pwb_addr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_addr (take_addr),
        .addr_in   (addr_in),
        .take_byte (take_byte),
        .page      (page),
        .ofs       (ofs)
    );

    pwb_slots #(.DATA_W(DATA_W), .SLOTS(PAGE_BYTES), .OFS_W(OFS_W)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_byte  (take_byte),
        .wr_slot    (ofs),
        .byte_data  (byte_data),
        .drop_all   (drop_all),
        .drain_step (drain_step),
        .pick_slot  (pick_slot),
        .pick_data  (pick_data),
        .any_valid  (any_valid),
        .one_left   (one_left),
        .valid_mask (valid_mask)
    );

    assign wr_en     = drain_step;
    assign wr_addr   = {page, pick_slot};
    assign wr_data   = pick_data;
    assign next_addr = {page, ofs};

    AST_ORDER_UP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> wr_addr[OFS_W-1:0] > $past(wr_addr[OFS_W-1:0])); // R6
    AST_ONE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> wr_addr[ADDR_W-1:OFS_W] == $past(wr_addr[ADDR_W-1:OFS_W])); // R6
    AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ack |-> $past(byte_valid)); // R5
    AST_EMPTY_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> valid_mask == '0); // R11
endmodule

// File: tb/sim_page_write_buffer.sv
module sim_page_write_buffer;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_load = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          byte_valid = 1'b0;
    logic [DW-1:0] byte_data = '0;
    logic          commit = 1'b0;
    logic          clear = 1'b0;
    logic          byte_ack, busy, wr_en;
    logic [AW-1:0] wr_addr, next_addr;
    logic [DW-1:0] wr_data;

    always #5 clk = ~clk;

    page_write_buffer u0 (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_valid(byte_valid), .byte_data(byte_data), .commit(commit),
        .clear(clear), .byte_ack(byte_ack), .busy(busy), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .next_addr(next_addr)
    );

    int n_chk = 0;
    int n_err = 0;
    int writes_seen = 0;
    logic [AW-1:0] exp_a [$];
    logic [DW-1:0] exp_d [$];
    logic [AW-1:0] mon_a;
    logic [DW-1:0] mon_d;

    // reference model
    logic [DW-1:0] m_d [NS];
    bit            m_v [NS];
    logic [AW-1:0] m_addr = '0;
    bit            m_act = 1'b0;

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pop and compare every write
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            writes_seen++;
            chk("R9", {31'd0, busy}, 32'd1, "busy during write");
            if (exp_a.size() == 0) begin
                n_chk++;
                n_err++;
                $display("FAIL R6 unexpected write: actual=%0h expected=none", wr_addr);
            end else begin
                mon_a = exp_a.pop_front();
                mon_d = exp_d.pop_front();
                chk("R6", {21'd0, wr_addr}, {21'd0, mon_a}, "write address");
                chk("R6", {24'd0, wr_data}, {24'd0, mon_d}, "write data");
            end
        end
    end

    task automatic t_load(input logic [AW-1:0] a);
        @(negedge clk); addr_load = 1'b1; addr_in = a;
        @(negedge clk); addr_load = 1'b0;
        m_act = 1'b1; m_addr = a;
        for (int i = 0; i < NS; i++) m_v[i] = 1'b0;
        chk("R2", {21'd0, next_addr}, {21'd0, a}, "next_addr after load");
    endtask

    task automatic t_byte(input logic [DW-1:0] d);
        bit was_act;
        was_act = m_act;
        @(negedge clk); byte_valid = 1'b1; byte_data = d;
        @(negedge clk); byte_valid = 1'b0;
        if (m_act) begin
            m_d[m_addr[3:0]] = d;
            m_v[m_addr[3:0]] = 1'b1;
            m_addr[3:0] = m_addr[3:0] + 4'd1;
        end
        chk("R5", {31'd0, byte_ack}, {31'd0, was_act}, "byte_ack");
        chk("R3", {21'd0, next_addr}, {21'd0, m_addr}, "next_addr after byte");
    endtask

    task automatic t_clear();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        m_act = 1'b0;
        for (int i = 0; i < NS; i++) m_v[i] = 1'b0;
        chk("R10", {21'd0, next_addr}, {21'd0, m_addr}, "next_addr after clear");
    endtask

    task automatic t_commit(input string req, input int exp_n,
                            input bit disturb, input bit with_byte);
        int base;
        base = writes_seen;
        if (m_act) begin
            for (int i = 0; i < NS; i++) begin
                if (m_v[i]) begin
                    exp_a.push_back({m_addr[AW-1:4], 4'(i)});
                    exp_d.push_back(m_d[i]);
                end
                m_v[i] = 1'b0;
            end
        end
        m_act = 1'b0;
        @(negedge clk); commit = 1'b1; byte_valid = with_byte; byte_data = 8'h5A;
        @(negedge clk); commit = 1'b0; byte_valid = 1'b0;
        if (with_byte) chk("R12", {31'd0, byte_ack}, 32'd0, "byte with commit acked");
        while (busy) begin
            if (disturb) begin
                byte_valid = 1'b1; byte_data = 8'hEE;
                addr_load = 1'b1; addr_in = '1; clear = 1'b1; commit = 1'b1;
            end
            @(negedge clk);
        end
        byte_valid = 1'b0; addr_load = 1'b0; clear = 1'b0; commit = 1'b0;
        @(negedge clk);
        chk(req, writes_seen - base, exp_n, "write count");
        chk("R6", exp_a.size(), 0, "expected writes left");
        if (disturb)
            chk("R9", {21'd0, next_addr}, {21'd0, m_addr}, "next_addr after busy inputs");
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", {31'd0, wr_en}, 0, "wr_en in reset");
        chk("R1", {31'd0, busy}, 0, "busy in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {31'd0, byte_ack}, 0, "byte_ack after reset");
        chk("R1", {21'd0, next_addr}, 0, "next_addr after reset");

        // basic three-byte transaction
        t_load(11'h123);
        t_byte(8'hA1); t_byte(8'hA2); t_byte(8'hA3);
        t_commit("R6", 3, 1'b0, 1'b0);
        chk("R3", {21'd0, next_addr}, 32'h126, "pointer after commit");

        // wrap inside the page, committed in ascending slot order
        t_load(11'h3FE);
        t_byte(8'h10); t_byte(8'h11); t_byte(8'h12); t_byte(8'h13);
        chk("R3", {21'd0, next_addr}, 32'h3F2, "wrapped pointer");
        t_commit("R3", 4, 1'b0, 1'b0);

        // overflow: eighteen bytes fold onto slots 0 and 1
        t_load(11'h500);
        for (int i = 0; i < 18; i++) t_byte(8'(8'h40 + i));
        t_commit("R4", 16, 1'b0, 1'b0);

        // single byte
        t_load(11'h7FF);
        t_byte(8'hC7);
        t_commit("R7", 1, 1'b0, 1'b0);

        // R11: second commit after drain writes nothing
        t_commit("R11", 0, 1'b0, 1'b0);

        // R5: byte with no transaction is ignored
        t_byte(8'hBD);
        t_commit("R5", 0, 1'b0, 1'b0);

        // R8: address only, then commit
        t_load(11'h0A0);
        t_commit("R8", 0, 1'b0, 1'b0);

        // R10: clear drops bytes, keeps pointer
        t_load(11'h200);
        t_byte(8'h01); t_byte(8'h02);
        t_clear();
        t_byte(8'h03);
        t_commit("R10", 0, 1'b0, 1'b0);

        // R9: inputs during replay are ignored
        t_load(11'h2A8);
        t_byte(8'h71); t_byte(8'h72); t_byte(8'h73);
        t_commit("R9", 3, 1'b1, 1'b0);
        t_commit("R9", 0, 1'b0, 1'b0);

        // R12: commit beats a byte in the same cycle
        t_load(11'h310);
        t_byte(8'h91);
        t_commit("R12", 1, 1'b0, 1'b1);

        // R2/R12: a second address load restarts the transaction
        t_load(11'h040);
        t_byte(8'h11);
        t_load(11'h085);
        t_byte(8'h22);
        t_commit("R2", 1, 1'b0, 1'b0);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule